// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date in a chain of cascaded counters. A 64 Hz tick strobe, or in test mode rising edges on an external pin, feeds a six-stage prescaler. The prescaler produces one increment per second, and that increment ripples through seconds, minutes, hours, day of month, month and year. Most fields are BCD coded. The weekday is a plain binary count that advances with each new day, and a century bit flips each time the year wraps.

Software reaches every field through a small synchronous register port and reads its data one cycle after the read strobe. While a read strobe or a read-burst window is active, the counters hold still, so a multi-byte read cannot mix values from before and after a carry. An increment that falls due during the hold is kept and applied once the hold ends. A sticky voltage-low flag records a supply-low event until software writes it away.

Top module: `rtc_calendar_chain`

## Requirements
- R1: After reset, the registers read as follows. Control (address 0) reads 00. Seconds (address 1) reads 80, because the voltage-low flag is set and the count is 00. Minutes (2), hours (3) and weekday (5) read 00. Day (4) reads 01, month (6) reads 01 and year (7) reads 00.
- R2: Seconds and minutes count 00..59 in BCD and hours count 00..23 in BCD. Each field wraps to 00 and carries into the next field.
- R3: The weekday (address 5, bits 2:0) is binary. It advances by one each time the day field increments and wraps from 6 to 0.
- R4: The day (01..31 BCD) wraps to 01 after the month's last day and carries into the month. April, June, September and November end at 30, February ends at 28 or 29, and the other months end at 31. The month (01..12 BCD) wraps to 01 and carries into the year (00..99 BCD).
- R5: February has 29 days when the BCD year is divisible by 4. Year 00 counts as divisible by 4.
- R6: The century bit is bit 7 of the month register. It toggles when the year wraps from 99 to 00, and a write to the month register loads it.
- R7: The voltage-low flag is bit 7 of the seconds register. A one-cycle pulse on `vlow_evt` sets it. A write to the seconds register loads it from data bit 7, so it is cleared only by a software write.
- R8: Control bit 0 (halt) clears the 6-bit prescaler and holds it at zero. After halt is released, the first second increment comes on the 32nd source tick and each later one comes 64 ticks after the previous one.
- R9: Control bit 1 (external mode) takes the prescaler source from rising edges on `ext_clk_pin`, and `tick64_in` is then ignored.
- R10: While `reg_rd_en` or `rd_burst` is high, no time field changes. A second that falls due during the hold is applied exactly once after the hold ends.
- R11: Writes are masked to the implemented bits: minutes and seconds keep 7 bits, hours and day keep 6, and month keeps 5 plus the century bit. Addresses 8 and above read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick64_in | input | 1 | One-cycle strobe at 64 Hz from the internal divider |
| ext_clk_pin | input | 1 | Asynchronous test clock pin; its rising edges are used in external mode |
| vlow_evt | input | 1 | One-cycle pulse reporting a supply-low event |
| rd_burst | input | 1 | High while software performs a multi-register read |
| reg_rd_en | input | 1 | Read strobe |
| reg_wr_en | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd_en` |

## Verification
The bench loads dates just before each boundary and steps exactly one second. The boundaries are:
- the end of a 30-day month and of a 31-day month;
- February in leap years 00, 12 and 24 and in non-leap years 14 and 23;
- the year 99 wrap with the century bit starting at both values;
- the BCD month step from 09 to 10.

A design with a wrong month table or leap test stops at day 29, 30 or 31 of the wrong month. A design with a binary month increment would show month 0A. The prescaler test counts 31 and then 32 ticks after halt is released, and then 63 and 64 ticks. It catches a design that fires on a full 64-tick boundary first, or that is off by one tick. The hold test lets a second fall due during a burst read. A design that drops the pending increment, or applies it twice, shows up when the seconds register is read afterwards.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FW   = 8;
  localparam int NBCD = 6;

  // field indices of the BCD chain, least significant first
  localparam int F_SEC = 0;
  localparam int F_MIN = 1;
  localparam int F_HR  = 2;
  localparam int F_DAY = 3;
  localparam int F_MON = 4;
  localparam int F_YR  = 5;

  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_SEC  = 1;
  localparam int A_MIN  = 2;
  localparam int A_HR   = 3;
  localparam int A_DAY  = 4;
  localparam int A_WDAY = 5;
  localparam int A_MON  = 6;
  localparam int A_YR   = 7;

  localparam logic [2:0] WDAY_LAST = 3'd6;

  function automatic logic [FW-1:0] fld_lo(input int i);
    return (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [FW-1:0] fld_hi(input int i);
    case (i)
      F_SEC, F_MIN: return 8'h59;
      F_HR:         return 8'h23;
      F_DAY:        return 8'h31;
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  function automatic logic [FW-1:0] fld_mask(input int i);
    case (i)
      F_SEC, F_MIN: return 8'h7F;
      F_HR, F_DAY:  return 8'h3F;
      F_MON:        return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction

  function automatic int fld_addr(input int i);
    case (i)
      F_SEC:   return A_SEC;
      F_MIN:   return A_MIN;
      F_HR:    return A_HR;
      F_DAY:   return A_DAY;
      F_MON:   return A_MON;
      default: return A_YR;
    endcase
  endfunction
endpackage

// File: rtl/rtc_tick_src.sv
module rtc_tick_src (
  input  logic clk,
  input  logic rst,
  input  logic ext_mode,
  input  logic tick64_in,
  input  logic ext_clk_pin,
  output logic step
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_clk_pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb begin
    if (ext_mode) step = s2 & ~s3;
    else          step = tick64_in;
  end
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic halt,
  input  logic step,
  output logic sec_tick
);
  localparam logic [DIV_BITS-1:0] FIRE_AT = DIV_BITS'((1 << (DIV_BITS-1)) - 1);

  logic [DIV_BITS-1:0] cnt;

  assign sec_tick = step & ~halt & (cnt == FIRE_AT);

  always_ff @(posedge clk) begin
    if (rst || halt) cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] mon,
  input  logic [7:0] yr,
  output logic [7:0] last_day
);
  logic [1:0] mod4;
  logic       leap;

  always_comb begin
    // 10*t + o is divisible by 4 exactly when 2*t + o is
    mod4 = {yr[4], 1'b0} + yr[1:0];
    leap = (mod4 == 2'b00);
    case (mon[4:0])
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] LO   = 8'h00,
  parameter logic [7:0] MASK = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [7:0] ld_val,
  input  logic       inc,
  input  logic [7:0] hi,
  output logic [7:0] q,
  output logic       at_max
);
  logic [7:0] nxt;

  always_comb begin
    at_max = (q >= hi);
    if (at_max)               nxt = LO;
    else if (q[3:0] >= 4'd9)  nxt = {q[7:4] + 4'd1, 4'd0};
    else                      nxt = q + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= LO;
    else if (ld)  q <= ld_val & MASK;
    else if (inc) q <= nxt;
  end
endmodule

// File: rtl/rtc_calendar_chain.sv
module rtc_calendar_chain
  import rtc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DIV_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick64_in,
  input  logic              ext_clk_pin,
  input  logic              vlow_evt,
  input  logic              rd_burst,
  input  logic              reg_rd_en,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [FW-1:0]     reg_wdata,
  output logic [FW-1:0]     reg_rdata
);
  logic halt, ext_mode, vl, century, pend;
  logic step, sec_tick, freeze, apply, yr_wrap;
  logic [2:0] wday;
  logic [7:0] day_hi;
  logic [NBCD-1:0][FW-1:0] fld_q;
  logic [NBCD-1:0][FW-1:0] fld_hi_v;
  logic [NBCD-1:0] at_max, inc_v, wr_fld;
  logic [FW-1:0] rd_mux;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  rtc_tick_src u_src (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .tick64_in(tick64_in),
    .ext_clk_pin(ext_clk_pin), .step(step)
  );

  rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_pre (
    .clk(clk), .rst(rst), .halt(halt), .step(step), .sec_tick(sec_tick)
  );

  rtc_month_len u_mlen (
    .mon(fld_q[F_MON]), .yr(fld_q[F_YR]), .last_day(day_hi)
  );

  assign freeze = rd_burst | reg_rd_en;
  assign apply  = (sec_tick | pend) & ~freeze & ~reg_wr_en;

  always_comb begin
    logic c;
    c = apply;
    for (int i = 0; i < NBCD; i++) begin
      inc_v[i]    = c;
      c           = c & at_max[i];
      fld_hi_v[i] = (i == F_DAY) ? day_hi : fld_hi(i);
      wr_fld[i]   = reg_wr_en & hit(reg_addr, fld_addr(i));
    end
    yr_wrap = c;
  end

  for (genvar gi = 0; gi < NBCD; gi++) begin : g_fld
    rtc_bcd_field #(.LO(fld_lo(gi)), .MASK(fld_mask(gi))) u_fld (
      .clk(clk), .rst(rst), .ld(wr_fld[gi]), .ld_val(reg_wdata),
      .inc(inc_v[gi]), .hi(fld_hi_v[gi]), .q(fld_q[gi]), .at_max(at_max[gi])
    );
  end

  // held increment across a read hold or a write cycle
  always_ff @(posedge clk) begin
    if (rst)           pend <= 1'b0;
    else if (apply)    pend <= 1'b0;
    else if (sec_tick) pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt     <= 1'b0;
      ext_mode <= 1'b0;
    end else if (reg_wr_en && hit(reg_addr, A_CTRL)) begin
      halt     <= reg_wdata[0];
      ext_mode <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                     vl <= 1'b1;
    else if (vlow_evt)                           vl <= 1'b1;
    else if (reg_wr_en && hit(reg_addr, A_SEC))  vl <= reg_wdata[7];
  end

  always_ff @(posedge clk) begin
    if (rst)                                     wday <= 3'd0;
    else if (reg_wr_en && hit(reg_addr, A_WDAY)) wday <= reg_wdata[2:0];
    else if (inc_v[F_DAY])                       wday <= (wday >= WDAY_LAST) ? 3'd0 : wday + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                     century <= 1'b0;
    else if (reg_wr_en && hit(reg_addr, A_MON))  century <= reg_wdata[7];
    else if (yr_wrap)                            century <= ~century;
  end

  always_comb begin
    rd_mux = '0;
    if (hit(reg_addr, A_CTRL)) rd_mux = {6'd0, ext_mode, halt};
    if (hit(reg_addr, A_SEC))  rd_mux = {vl, fld_q[F_SEC][6:0]};
    if (hit(reg_addr, A_MIN))  rd_mux = fld_q[F_MIN];
    if (hit(reg_addr, A_HR))   rd_mux = fld_q[F_HR];
    if (hit(reg_addr, A_DAY))  rd_mux = fld_q[F_DAY];
    if (hit(reg_addr, A_WDAY)) rd_mux = {5'd0, wday};
    if (hit(reg_addr, A_MON))  rd_mux = {century, fld_q[F_MON][6:0]};
    if (hit(reg_addr, A_YR))   rd_mux = fld_q[F_YR];
  end

  always_ff @(posedge clk) begin
    if (rst)            reg_rdata <= '0;
    else if (reg_rd_en) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_calendar_chain_chk.sv
module rtc_calendar_chain_chk
  import rtc_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    reg_wr_en,
  input logic                    vlow_evt,
  input logic                    freeze,
  input logic                    apply,
  input logic                    sec_tick,
  input logic                    pend,
  input logic                    yr_wrap,
  input logic                    vl,
  input logic                    century,
  input logic [2:0]              wday,
  input logic [NBCD-1:0][FW-1:0] fld_q
);
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (apply && fld_q[F_SEC] == 8'h59) |=> (fld_q[F_SEC] == 8'h00));

  a_r2_sec_digit: assert property (@(posedge clk) disable iff (rst)
    fld_q[F_SEC][3:0] <= 4'd9);

  a_r3_wday_range: assert property (@(posedge clk) disable iff (rst)
    wday <= WDAY_LAST);

  a_r6_century_flip: assert property (@(posedge clk) disable iff (rst)
    (yr_wrap && !reg_wr_en) |=> (century != $past(century)));

  a_r7_vl_sticky: assert property (@(posedge clk) disable iff (rst)
    vlow_evt |=> vl);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (freeze && !reg_wr_en) |=> $stable(fld_q));

  a_r10_pend_keep: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !apply) |=> pend);
endmodule

bind rtc_calendar_chain rtc_calendar_chain_chk u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .vlow_evt(vlow_evt),
  .freeze(freeze), .apply(apply), .sec_tick(sec_tick), .pend(pend),
  .yr_wrap(yr_wrap), .vl(vl), .century(century), .wday(wday), .fld_q(fld_q)
);

// File: tb/rtc_calendar_chain_bench.sv
module rtc_calendar_chain_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick64_in = 1'b0, ext_clk_pin = 1'b0, vlow_evt = 1'b0, rd_burst = 1'b0;
  logic reg_rd_en = 1'b0, reg_wr_en = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  rtc_calendar_chain u_rtc_calendar_chain (
    .clk(clk), .rst(rst), .tick64_in(tick64_in), .ext_clk_pin(ext_clk_pin),
    .vlow_evt(vlow_evt), .rd_burst(rd_burst), .reg_rd_en(reg_rd_en),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // {sec,min,hr,day,wday,mon,yr} loaded, then expected after one second
  localparam logic [111:0] VEC [16] = '{
    {56'h56_34_12_15_02_06_23, 56'h57_34_12_15_02_06_23}, // R2
    {56'h59_59_23_31_06_12_99, 56'h00_00_00_01_00_81_00}, // R4 R6
    {56'h59_59_23_28_03_02_24, 56'h00_00_00_29_04_02_24}, // R5
    {56'h59_59_23_28_03_02_23, 56'h00_00_00_01_04_03_23}, // R5
    {56'h59_59_23_29_01_02_00, 56'h00_00_00_01_02_03_00}, // R5
    {56'h59_59_23_30_05_04_10, 56'h00_00_00_01_06_05_10}, // R4
    {56'h59_59_23_30_00_11_31, 56'h00_00_00_01_01_12_31}, // R4
    {56'h59_59_23_30_04_01_05, 56'h00_00_00_31_05_01_05}, // R4
    {56'h59_59_10_07_02_08_45, 56'h00_00_11_07_02_08_45}, // R2
    {56'h59_59_23_28_06_02_00, 56'h00_00_00_29_00_02_00}, // R5 R3
    {56'h59_59_23_31_06_92_99, 56'h00_00_00_01_00_01_00}, // R6
    {56'h59_59_23_28_02_02_14, 56'h00_00_00_01_03_03_14}, // R5
    {56'h59_59_23_28_02_02_12, 56'h00_00_00_29_03_02_12}, // R5
    {56'h59_59_23_31_01_08_50, 56'h00_00_00_01_02_09_50}, // R4
    {56'h59_59_23_31_01_07_50, 56'h00_00_00_01_02_08_50}, // R4
    {56'h59_59_23_30_03_09_77, 56'h00_00_00_01_04_10_77}  // R4
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = 4'(a);
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick64_in = 1'b1;
      @(negedge clk); tick64_in = 1'b0;
    end
  endtask

  task automatic ext_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ext_clk_pin = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk_pin = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic restart_prescaler();
    wr(0, 8'h01);
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(0, d); chk("R1", "ctrl", d, 8'h00);
    rd(1, d); chk("R1", "sec", d, 8'h80);
    rd(2, d); chk("R1", "min", d, 8'h00);
    rd(3, d); chk("R1", "hr", d, 8'h00);
    rd(4, d); chk("R1", "day", d, 8'h01);
    rd(5, d); chk("R1", "wday", d, 8'h00);
    rd(6, d); chk("R1", "mon", d, 8'h01);
    rd(7, d); chk("R1", "yr", d, 8'h00);

    // R11 unused address and write masks
    rd(9, d); chk("R11", "unused addr", d, 8'h00);
    wr(2, 8'hB5); rd(2, d); chk("R11", "min mask", d, 8'h35);
    wr(3, 8'hE2); rd(3, d); chk("R11", "hr mask", d, 8'h22);

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 16; v++) begin
      wr(0, 8'h01);
      for (int f = 0; f < 7; f++) wr(f + 1, VEC[v][111 - 8*f -: 8]);
      wr(0, 8'h00);
      ticks(32);
      for (int f = 0; f < 7; f++) begin
        rd(f + 1, d);
        chk("R2/R3/R4/R5/R6", $sformatf("vec%0d field%0d", v, f), d, VEC[v][55 - 8*f -: 8]);
      end
    end

    // R8 prescaler: 32 ticks to first second, then 64
    wr(0, 8'h01); wr(1, 8'h00); wr(0, 8'h00);
    ticks(31); rd(1, d); chk("R8", "after 31", d, 8'h00);
    ticks(1);  rd(1, d); chk("R8", "after 32", d, 8'h01);
    ticks(63); rd(1, d); chk("R8", "after 95", d, 8'h01);
    ticks(1);  rd(1, d); chk("R8", "after 96", d, 8'h02);
    ticks(20); restart_prescaler();
    ticks(31); rd(1, d); chk("R8", "rehalt 31", d, 8'h02);
    ticks(1);  rd(1, d); chk("R8", "rehalt 32", d, 8'h03);
    wr(0, 8'h01); ticks(40); rd(1, d); chk("R8", "held halt", d, 8'h03);
    wr(0, 8'h00);

    // R10 hold during a burst read, one deferred second
    wr(0, 8'h01); wr(1, 8'h10); wr(0, 8'h00);
    @(negedge clk); rd_burst = 1'b1;
    ticks(32);
    rd(1, d); chk("R10", "frozen", d, 8'h10);
    @(negedge clk); rd_burst = 1'b0;
    repeat (2) @(negedge clk);
    rd(1, d); chk("R10", "released", d, 8'h11);
    ticks(63); rd(1, d); chk("R10", "no double", d, 8'h11);

    // R7 voltage-low flag
    @(negedge clk); vlow_evt = 1'b1;
    @(negedge clk); vlow_evt = 1'b0;
    rd(1, d); chk("R7", "vl set", d, 8'h91);
    repeat (5) @(negedge clk);
    rd(1, d); chk("R7", "vl sticky", d, 8'h91);
    wr(1, 8'h25); rd(1, d); chk("R7", "vl cleared", d, 8'h25);

    // R9 external tick mode
    wr(0, 8'h03); wr(0, 8'h02);
    rd(0, d); chk("R9", "ctrl", d, 8'h02);
    ticks(40); rd(1, d); chk("R9", "tick64 ignored", d, 8'h25);
    ext_pulses(31); rd(1, d); chk("R9", "ext 31", d, 8'h25);
    ext_pulses(1);  rd(1, d); chk("R9", "ext 32", d, 8'h26);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule